// File: doc/BRIEF.md
# Masked Lane Integer Reduction Unit

This unit folds 32 lane values, each 32 bits wide, into one 32-bit result. A lane contributes only when its bit is set in the participation mask and clear in the exited-lane mask. One datapath covers three bitwise operations (AND, OR, XOR) and three arithmetic ones (add, min, max). A signedness flag chooses whether min and max compare as two's complement or as unsigned values.

A caller places all lane values on a flattened bus, sets the two masks, the opcode and the signedness flag, and pulses `start` for one cycle. The operands pass through a five-level pipelined binary tree. The result comes out together with a one-cycle `done` pulse. The tree accepts a new operation on every cycle, so operations can be issued back to back. When no lane is active, the unit returns the identity value of the selected operation and raises a flag that marks the result as empty.

Top module: `lane_reduce`

## Requirements
- R1: Lane i sits at bits [32*i+31 : 32*i] of `laneData`. It contributes only when `laneMask[i]` is 1 and `exitedMask[i]` is 0. Every other lane has no effect on `result`.
- R2: `opSel` encodes the operations as 0 = AND, 1 = OR, 2 = XOR, 3 = add, 4 = min, 5 = max. Codes 6 and 7 are reserved. AND, OR and XOR act bit by bit on the active lanes.
- R3: For add, `result` holds the low 32 bits of the sum of the active lanes. Any carry out of bit 31 is dropped.
- R4: With `isSigned` = 0, min and max compare operands as unsigned 32-bit magnitudes.
- R5: With `isSigned` = 1, min and max compare operands as two's-complement 32-bit integers.
- R6: Each cycle in which `start` is 1 produces a one-cycle `done` pulse exactly 5 clock edges later, with `result` valid in that cycle. A start is accepted on every cycle, and `done` never rises without a matching start.
- R7: When no lane is active, `noneActive` is 1 with `done`. `result` then holds the identity value: 0xFFFFFFFF for AND, 0 for OR, XOR and add, 0xFFFFFFFF for unsigned min, 0x7FFFFFFF for signed min, 0 for unsigned max, and 0x80000000 for signed max. When at least one lane is active, `noneActive` is 0.
- R8: While `rst_n` is 0, `done`, `result` and `noneActive` are all 0.
- R9: `isSigned` has no effect on the result of AND, OR, XOR or add.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launches one reduction from the current inputs |
| laneData | input | 1024 | Lane values, lane i in bits [32*i+31 : 32*i] |
| laneMask | input | 32 | Participation mask, bit i selects lane i |
| exitedMask | input | 32 | Lanes marked as exited, bit i for lane i |
| opSel | input | 3 | Operation code (see R2) |
| isSigned | input | 1 | 1 selects two's-complement compare for min and max |
| result | output | 32 | Reduction result |
| noneActive | output | 1 | Set with `done` when no lane took part |
| done | output | 1 | One-cycle pulse marking `result` valid |

## Verification
Every result, together with its empty flag and its `done` pulse, is due on the fifth rising edge after the edge that samples `start`. No other output event exists. The bench computes each expected value at the moment it drives a start and stores it in a slot five edges ahead. At every falling edge it compares the outputs with the slot for the current edge count, so a pulse that comes early, late, twice or not at all is reported against R6. Back-to-back starts, random gaps between starts, and directed corner cases (carry overflow, empty masks, exited lanes, signed against unsigned extremes) all go through this same schedule.

// File: rtl/lane_reduce_pkg.sv
package lane_reduce_pkg;

  localparam int LANE_COUNT  = 32;
  localparam int DATA_W      = 32;
  localparam int TREE_LEVELS = $clog2(LANE_COUNT);

  typedef enum logic [2:0] {
    OP_AND = 3'd0,
    OP_OR  = 3'd1,
    OP_XOR = 3'd2,
    OP_ADD = 3'd3,
    OP_MIN = 3'd4,
    OP_MAX = 3'd5
  } opcode_e;

  // Strobes from control to datapath: one load enable per tree level.
  typedef struct packed {
    logic [TREE_LEVELS-1:0] load;
  } stage_ctrl_t;

  function automatic logic [DATA_W-1:0] identityOf(opcode_e op, logic sgn);
    case (op)
      OP_AND:  return {DATA_W{1'b1}};
      OP_MIN:  return sgn ? {1'b0, {(DATA_W-1){1'b1}}} : {DATA_W{1'b1}};
      OP_MAX:  return sgn ? {1'b1, {(DATA_W-1){1'b0}}} : {DATA_W{1'b0}};
      default: return {DATA_W{1'b0}};
    endcase
  endfunction

  function automatic logic lessThan(logic [DATA_W-1:0] a, logic [DATA_W-1:0] b, logic sgn);
    if (sgn) return $signed(a) < $signed(b);
    return a < b;
  endfunction

  function automatic logic [DATA_W-1:0] combineOf(opcode_e op, logic sgn,
                                                   logic [DATA_W-1:0] a, logic [DATA_W-1:0] b);
    case (op)
      OP_AND:  return a & b;
      OP_OR:   return a | b;
      OP_XOR:  return a ^ b;
      OP_ADD:  return a + b;
      OP_MIN:  return lessThan(a, b, sgn) ? a : b;
      OP_MAX:  return lessThan(a, b, sgn) ? b : a;
      default: return a | b;
    endcase
  endfunction

endpackage

// File: rtl/lane_reduce_ctrl.sv
module lane_reduce_ctrl
  import lane_reduce_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  output stage_ctrl_t strobe,
  output logic        done
);

  logic [TREE_LEVELS-1:0] validQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) validQ <= '0;
    else        validQ <= {validQ[TREE_LEVELS-2:0], start};
  end

  assign strobe.load = {validQ[TREE_LEVELS-2:0], start};
  assign done        = validQ[TREE_LEVELS-1];

  // R6: a done pulse always traces back to a start issued TREE_LEVELS edges earlier
  assert_done_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(start, TREE_LEVELS));

endmodule

// File: rtl/lane_reduce_datapath.sv
module lane_reduce_datapath
  import lane_reduce_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  stage_ctrl_t                  strobe,
  input  logic [LANE_COUNT*DATA_W-1:0] laneData,
  input  logic [LANE_COUNT-1:0]        activeMask,
  input  opcode_e                      opSel,
  input  logic                         isSigned,
  output logic [DATA_W-1:0]            result,
  output logic                         noneActive
);

  logic [DATA_W-1:0] seedIdentity;
  logic [DATA_W-1:0] maskedLane [LANE_COUNT];

  assign seedIdentity = identityOf(opSel, isSigned);

  // Inactive lanes are replaced by the operation's identity before the tree.
  for (genvar i = 0; i < LANE_COUNT; i++) begin : gMask
    assign maskedLane[i] = activeMask[i] ? laneData[i*DATA_W +: DATA_W] : seedIdentity;
  end

  for (genvar l = 0; l < TREE_LEVELS; l++) begin : gLevel
    localparam int NODES = LANE_COUNT >> (l + 1);

    logic [DATA_W-1:0] srcNode [2*NODES];
    logic [DATA_W-1:0] nodeQ   [NODES];
    opcode_e           opIn, opQ;
    logic              sgnIn, sgnQ, emptyIn, emptyQ;

    if (l == 0) begin : gFirst
      assign opIn    = opSel;
      assign sgnIn   = isSigned;
      assign emptyIn = (activeMask == '0);
      for (genvar i = 0; i < 2*NODES; i++) begin : gSrc
        assign srcNode[i] = maskedLane[i];
      end
    end else begin : gNext
      assign opIn    = gLevel[l-1].opQ;
      assign sgnIn   = gLevel[l-1].sgnQ;
      assign emptyIn = gLevel[l-1].emptyQ;
      for (genvar i = 0; i < 2*NODES; i++) begin : gSrc
        assign srcNode[i] = gLevel[l-1].nodeQ[i];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        opQ    <= OP_AND;
        sgnQ   <= 1'b0;
        emptyQ <= 1'b0;
        for (int j = 0; j < NODES; j++) nodeQ[j] <= '0;
      end else if (strobe.load[l]) begin
        opQ    <= opIn;
        sgnQ   <= sgnIn;
        emptyQ <= emptyIn;
        for (int j = 0; j < NODES; j++)
          nodeQ[j] <= combineOf(opIn, sgnIn, srcNode[2*j], srcNode[2*j+1]);
      end
    end
  end

  assign result     = gLevel[TREE_LEVELS-1].nodeQ[0];
  assign noneActive = gLevel[TREE_LEVELS-1].emptyQ;

  // R6: the output stage changes only when its level is loaded
  assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.load[TREE_LEVELS-1] |=> $stable(result) && $stable(noneActive));

endmodule

// File: rtl/lane_reduce.sv
module lane_reduce
  import lane_reduce_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic [LANE_COUNT*DATA_W-1:0] laneData,
  input  logic [LANE_COUNT-1:0]        laneMask,
  input  logic [LANE_COUNT-1:0]        exitedMask,
  input  logic [2:0]                   opSel,
  input  logic                         isSigned,
  output logic [DATA_W-1:0]            result,
  output logic                         noneActive,
  output logic                         done
);

  stage_ctrl_t             strobe;
  logic [LANE_COUNT-1:0]   activeMask;

  assign activeMask = laneMask & ~exitedMask;

  lane_reduce_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .strobe (strobe),
    .done   (done)
  );

  lane_reduce_datapath u_datapath (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .laneData   (laneData),
    .activeMask (activeMask),
    .opSel      (opcode_e'(opSel)),
    .isSigned   (isSigned),
    .result     (result),
    .noneActive (noneActive)
  );

  // R1: the empty flag reflects the masks sampled with the matching start
  assert_empty_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> noneActive == ($past(laneMask & ~exitedMask, TREE_LEVELS) == '0));

  // R7: an empty reduction yields the identity of the issued operation
  assert_empty_identity_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && noneActive) |->
      result == identityOf(opcode_e'($past(opSel, TREE_LEVELS)), $past(isSigned, TREE_LEVELS)));

  // R8: no output activity while held in reset
  always_comb begin
    if (!rst_n) assert_reset_quiet_R8: assert (!done || $isunknown(done));
  end

endmodule

// File: tb/lane_reduce_bench.sv
`timescale 1ns/1ps
module lane_reduce_bench;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [1023:0] laneData = '0;
  logic [31:0]   laneMask = '0;
  logic [31:0]   exitedMask = '0;
  logic [2:0]    opSel = '0;
  logic          isSigned = 1'b0;
  logic [31:0]   result;
  logic          noneActive;
  logic          done;

  int checks = 0;
  int fails  = 0;
  int posCount = 0;
  bit checkEn = 1'b0;
  bit finished = 1'b0;

  bit          expValid [8];
  logic [31:0] expRes   [8];
  bit          expNone  [8];
  string       expTag   [8];

  lane_reduce u_lane_reduce (
    .clk(clk), .rst_n(rst_n), .start(start), .laneData(laneData),
    .laneMask(laneMask), .exitedMask(exitedMask), .opSel(opSel),
    .isSigned(isSigned), .result(result), .noneActive(noneActive), .done(done)
  );

  always #5 clk = ~clk;
  always @(posedge clk) posCount <= posCount + 1;

  function automatic logic [31:0] refIdentity(int op, bit s);
    if (op == 0) return 32'hFFFF_FFFF;
    if (op == 4) return s ? 32'h7FFF_FFFF : 32'hFFFF_FFFF;
    if (op == 5) return s ? 32'h8000_0000 : 32'h0;
    return 32'h0;
  endfunction

  function automatic logic [31:0] refReduce(logic [1023:0] d, logic [31:0] m, logic [31:0] e,
                                            int op, bit s, output bit none);
    logic [31:0] acc;
    logic [31:0] v;
    bit less;
    none = 1'b1;
    acc = 32'h0;
    for (int i = 0; i < 32; i++) begin
      if (m[i] && !e[i]) begin
        v = d[i*32 +: 32];
        if (none) acc = v;
        else begin
          less = s ? ($signed(v) < $signed(acc)) : (v < acc);
          case (op)
            0: acc = acc & v;
            1: acc = acc | v;
            2: acc = acc ^ v;
            3: acc = acc + v;
            4: if (less) acc = v;
            default: if (!less && v != acc) acc = v;
          endcase
        end
        none = 1'b0;
      end
    end
    if (none) acc = refIdentity(op, s);
    return acc;
  endfunction

  function automatic string tagFor(int op, bit s);
    if (op < 3)  return "R2";
    if (op == 3) return "R3";
    return s ? "R5" : "R4";
  endfunction

  // Called at a falling edge; holds the inputs for one cycle.
  task automatic drive(bit go, logic [1023:0] d, logic [31:0] m, logic [31:0] e,
                       int op, bit s, string tag);
    bit none;
    int slot;
    start = go; laneData = d; laneMask = m; exitedMask = e;
    opSel = op[2:0]; isSigned = s;
    if (go) begin
      slot = (posCount + 5) % 8;
      expRes[slot]   = refReduce(d, m, e, op, s, none);
      expNone[slot]  = none;
      expValid[slot] = 1'b1;
      expTag[slot]   = none ? "R7" : tag;
    end
    @(negedge clk);
    start = 1'b0;
  endtask

  function automatic logic [1023:0] randLanes();
    logic [1023:0] d;
    for (int i = 0; i < 32; i++) begin
      case ($urandom % 4)
        0: d[i*32 +: 32] = $urandom % 16;
        1: d[i*32 +: 32] = 32'h8000_0000 | $urandom;
        default: d[i*32 +: 32] = $urandom;
      endcase
    end
    return d;
  endfunction

  // Result checker: one slot per edge count, sampled at the falling edge.
  always @(negedge clk) begin
    int k;
    k = posCount % 8;
    if (checkEn && (expValid[k] || done)) begin
      checks++;
      if (done !== expValid[k]) begin
        fails++;
        $display("FAIL R6 done=%0b expected %0b at edge %0d", done, expValid[k], posCount);
      end else if (result !== expRes[k] || noneActive !== expNone[k]) begin
        fails++;
        $display("FAIL %s result=%h none=%0b expected %h none=%0b",
                 expTag[k], result, noneActive, expRes[k], expNone[k]);
      end
    end
    expValid[k] = 1'b0;
  end

  initial begin
    logic [1023:0] d;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) expValid[i] = 1'b0;

    repeat (3) @(negedge clk);
    checks++;  // R8 reset state
    if (done !== 1'b0 || result !== 32'h0 || noneActive !== 1'b0) begin
      fails++;
      $display("FAIL R8 done=%0b result=%h none=%0b expected 0 00000000 0", done, result, noneActive);
    end
    rst_n = 1'b1;
    checkEn = 1'b1;
    @(negedge clk);

    // R3: carry out of bit 31 is dropped
    drive(1, {32{32'hFFFF_FFFF}}, 32'hFFFF_FFFF, 32'h0, 3, 0, "R3");
    // R7: empty mask, every op and sign, back to back (R6)
    for (int op = 0; op < 6; op++)
      for (int s = 0; s < 2; s++)
        drive(1, randLanes(), 32'h0, 32'h0, op, s[0], "R7");
    // R1: all lanes selected but all exited
    drive(1, randLanes(), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 0, "R1");
    // R1: exited lanes hold values that would change the result
    d = '0; d[3*32 +: 32] = 32'h5; d[9*32 +: 32] = 32'hFFFF_0000;
    drive(1, d, 32'h0000_0208, 32'h0000_0200, 5, 0, "R1");
    drive(1, d, 32'h0000_0200, 32'h0000_0000, 5, 0, "R1");
    // R4 / R5: 0x80000000 against 1
    d = '0; d[7*32 +: 32] = 32'h8000_0000; d[20*32 +: 32] = 32'h1;
    drive(1, d, 32'h0010_0080, 32'h0, 4, 0, "R4");
    drive(1, d, 32'h0010_0080, 32'h0, 4, 1, "R5");
    drive(1, d, 32'h0010_0080, 32'h0, 5, 0, "R4");
    drive(1, d, 32'h0010_0080, 32'h0, 5, 1, "R5");
    // R9: signedness flag has no effect on bitwise and add
    d = randLanes();
    for (int op = 0; op < 4; op++) begin
      drive(1, d, 32'hF0F0_3C3C, 32'h0101_0000, op, 0, "R9");
      drive(1, d, 32'hF0F0_3C3C, 32'h0101_0000, op, 1, "R9");
    end
    repeat (3) @(negedge clk);

    // Random mix with random gaps between starts
    for (int n = 0; n < 600; n++) begin
      int op;
      bit s;
      logic [31:0] m;
      op = $urandom % 6;
      s  = $urandom % 2;
      case ($urandom % 5)
        0: m = 32'hFFFF_FFFF;
        1: m = 32'h1 << ($urandom % 32);
        2: m = $urandom & $urandom & $urandom;
        default: m = $urandom;
      endcase
      drive(($urandom % 4) != 0, randLanes(), m, ($urandom % 3 == 0) ? $urandom : 32'h0,
            op, s, tagFor(op, s));
    end
    repeat (8) @(negedge clk);

    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule